// File: doc/BRIEF.md
# Timed Clock Glitch Inserter

This block sits in the clock path of a target device, between the target's ordinary clock and the pin that drives it. While idle it passes the ordinary clock through unchanged. When a trigger arrives, it swaps in a disturbed clock for a programmed window and then returns to the ordinary clock. The disturbed clock is the exclusive-OR of two free-running oscillator signals that are asynchronous to each other. It therefore toggles on every edge of either oscillator and carries an irregular mix of fast and slow components.

The window length is counted on a separate timing clock, nominally 100 MHz, so one count is one 10 ns step. The duration input is 16 bits wide, so windows run from one step up to several hundred microseconds. The trigger is asynchronous and passes through a two-flop synchroniser before its rising edge is detected. A busy output stays high for exactly the programmed number of timing-clock cycles. Over that same span the target sees the mixed oscillator signal.

Top module: `glitch_inserter`

## Requirements
- R1: While `busy` is low, `tgt_clk` equals `norm_clk`. This includes the state during and directly after reset.
- R2: While `busy` is high, `tgt_clk` equals `osc_a` XOR `osc_b`.
- R3: `trig_in` is sampled by two flip-flops on `tick_clk`. After a rising edge of `trig_in`, `busy` is first seen high after the third rising edge of `tick_clk` that samples the new level. No window starts except from such an edge.
- R4: A window started with a nonzero `dur_cnt` of value D keeps `busy` high for exactly D consecutive `tick_clk` cycles.
- R5: A trigger edge seen while `dur_cnt` is zero starts no window, and `busy` stays low.
- R6: A rising edge of `trig_in` that is detected while a window is active is ignored. It neither lengthens the window nor starts a new one afterwards.
- R7: `dur_cnt` is sampled only in the cycle a window starts. Changing it during the window has no effect on that window's length.
- R8: Only a low-to-high transition of `trig_in` starts a window. Holding `trig_in` high starts one window only.
- R9: After reset, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tick_clk | input | 1 | Timing clock; one cycle is one duration step |
| rst_n | input | 1 | Active-low reset, synchronous to `tick_clk` |
| norm_clk | input | 1 | Ordinary clock for the target |
| osc_a | input | 1 | First free-running oscillator signal |
| osc_b | input | 1 | Second free-running oscillator signal |
| trig_in | input | 1 | Asynchronous start request; the rising edge is used |
| dur_cnt | input | 16 | Window length in `tick_clk` cycles; zero disables |
| tgt_clk | output | 1 | Clock delivered to the target |
| busy | output | 1 | High while the mixed signal replaces the ordinary clock |

## Verification
The only state in this block is the synchroniser chain and the down-counter. Any fault in either shows up at once in `busy` and `tgt_clk`.

A counter that loads the wrong value or counts at the wrong rate makes the window too long or too short by the first cycle after it should have ended. A synchroniser chain with the wrong depth shifts the rise of `busy` by a whole cycle relative to the trigger. Accepting a retrigger lengthens the window or starts a second one within a few cycles.

A selector that is inverted or stuck corrupts `tgt_clk` in the very first sample of either state.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

  // Value the window counter takes one tick later when nothing new is loaded.
  function automatic int unsigned count_after(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Disturbed clock: toggles on every edge of either oscillator.
  function automatic logic mix_osc(logic a, logic b);
    return a ^ b;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R8

endmodule

// File: rtl/window_timer.sv
module window_timer
  import glitch_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [CW-1:0] dur,
  output logic          busy_o,
  output logic          start_ok_o,
  output logic          ignored_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign busy_o     = (cnt_q != '0);
  assign start_ok_o = start_req && !busy_o && (dur != '0);
  assign ignored_o  = start_req && busy_o;

  always_comb begin
    if (start_ok_o) cnt_d = dur;
    else            cnt_d = CW'(count_after(int'(cnt_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok_o |=> (cnt_q == $past(dur))); // R4
  AST_ZERO_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy_o && dur == '0) |=> !busy_o); // R5
  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_o |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_STEADY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_RISE_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_ok_o)); // R3

endmodule

// File: rtl/clk_select.sv
module clk_select
  import glitch_pkg::*;
(
  input  logic sel,
  input  logic norm_clk,
  input  logic osc_a,
  input  logic osc_b,
  output logic out_clk
);
  logic mix_w;

  assign mix_w   = mix_osc(osc_a, osc_b);
  assign out_clk = sel ? mix_w : norm_clk;

endmodule

// File: rtl/glitch_inserter.sv
module glitch_inserter #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          tick_clk,
  input  logic          rst_n,
  input  logic          norm_clk,
  input  logic          osc_a,
  input  logic          osc_b,
  input  logic          trig_in,
  input  logic [CW-1:0] dur_cnt,
  output logic          tgt_clk,
  output logic          busy
);
  logic trig_rise_w;
  logic start_ok_w;
  logic ignored_w;
  logic busy_w;

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (tick_clk),
    .rst_n   (rst_n),
    .async_i (trig_in),
    .rise_o  (trig_rise_w)
  );

  window_timer #(.CW(CW)) u_timer (
    .clk        (tick_clk),
    .rst_n      (rst_n),
    .start_req  (trig_rise_w),
    .dur        (dur_cnt),
    .busy_o     (busy_w),
    .start_ok_o (start_ok_w),
    .ignored_o  (ignored_w)
  );

  clk_select u_sel (
    .sel      (busy_w),
    .norm_clk (norm_clk),
    .osc_a    (osc_a),
    .osc_b    (osc_b),
    .out_clk  (tgt_clk)
  );

  assign busy = busy_w;

  AST_IDLE_PASS: assert property (@(posedge tick_clk) disable iff (!rst_n)
    !busy |-> (tgt_clk == norm_clk)); // R1
  AST_WINDOW_MIX: assert property (@(posedge tick_clk) disable iff (!rst_n)
    busy |-> (tgt_clk == (osc_a != osc_b))); // R2
  AST_START_NEEDS_EDGE: assert property (@(posedge tick_clk) disable iff (!rst_n)
    start_ok_w |-> trig_rise_w); // R8
  AST_NO_START_WHEN_IGNORED: assert property (@(posedge tick_clk) disable iff (!rst_n)
    ignored_w |-> !start_ok_w); // R6

endmodule

// File: tb/test_glitch_inserter.sv
module test_glitch_inserter;
  logic        tick_clk = 1'b0;
  logic        rst_n    = 1'b0;
  logic        norm_clk = 1'b0;
  logic        osc_a    = 1'b0;
  logic        osc_b    = 1'b0;
  logic        trig_in  = 1'b0;
  logic [15:0] dur_cnt  = 16'd0;
  logic        tgt_clk;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;

  glitch_inserter i_glitch_inserter (
    .tick_clk (tick_clk),
    .rst_n    (rst_n),
    .norm_clk (norm_clk),
    .osc_a    (osc_a),
    .osc_b    (osc_b),
    .trig_in  (trig_in),
    .dur_cnt  (dur_cnt),
    .tgt_clk  (tgt_clk),
    .busy     (busy)
  );

  always #4 tick_clk = ~tick_clk;

  // Expected busy at the k-th falling edge after the trigger was raised.
  function automatic logic exp_busy(int k, int d);
    return (d != 0) && (k >= 3) && (k <= 2 + d);
  endfunction

  function automatic logic exp_out(logic win, logic n, logic a, logic b);
    if (win) return (a == b) ? 1'b0 : 1'b1;
    return n;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Raise the trigger and watch the window. Optionally drop and re-raise the
  // trigger mid-window, or change the duration after the start.
  task automatic pulse(input int d, input logic retrig, input logic change_dur);
    int bad_b = 0;
    int bad_t = 0;
    int hi    = 0;
    @(negedge tick_clk);
    dur_cnt = 16'(d);
    trig_in = 1'b1;
    for (int k = 1; k <= d + 8; k++) begin
      @(negedge tick_clk);
      if (busy !== exp_busy(k, d)) bad_b++;
      if (busy === 1'b1) hi++;
      norm_clk = 1'($urandom);
      osc_a    = 1'($urandom);
      osc_b    = 1'($urandom);
      #1;
      if (tgt_clk !== exp_out(exp_busy(k, d), norm_clk, osc_a, osc_b)) bad_t++;
      if (retrig && k == 4) trig_in = 1'b0;
      if (retrig && k == 8) trig_in = 1'b1;
      if (change_dur && k == 5) dur_cnt = 16'($urandom_range(1, 60));
    end
    trig_in = 1'b0;
    if (d == 0)
      chk(hi == 0, "R5", hi, 0);
    else if (retrig)
      chk(hi == d, "R6", hi, d);
    else if (change_dur)
      chk(hi == d, "R7", hi, d);
    else
      chk(hi == d, "R4", hi, d);
    chk(bad_b == 0, "R3", bad_b, 0);
    chk(bad_t == 0, "R1 R2", bad_t, 0);
    repeat (4) @(negedge tick_clk);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge tick_clk);
    norm_clk = 1'b1;
    #1;
    chk(tgt_clk === 1'b1, "R1", int'(tgt_clk), 1);
    rst_n = 1'b1;
    @(negedge tick_clk);
    chk(busy === 1'b0, "R9", int'(busy), 0);
    norm_clk = 1'b0;
    #1;
    chk(tgt_clk === 1'b0, "R1", int'(tgt_clk), 0);
    // Directed corners
    pulse(1, 1'b0, 1'b0);     // R4 shortest window
    pulse(0, 1'b0, 1'b0);     // R5 zero duration
    pulse(25, 1'b1, 1'b0);    // R6 retrigger inside window
    pulse(30, 1'b0, 1'b1);    // R7 duration changed mid-window
    pulse(300, 1'b0, 1'b0);   // R4 long window, trigger held high (R8)
    // Random windows
    for (int i = 0; i < 12; i++) begin
      int d = $urandom_range(1, 80);
      pulse(d, (d >= 20) && ($urandom_range(0, 1) == 1), ($urandom_range(0, 3) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule